// File: doc/BRIEF.md
# Configurable Four-Bit Storage Cluster

This block holds the storage of one programmable logic tile. Four storage elements each take one bit of data. The data comes either from the tile's lookup result or from a bypass input. Each element can act as an edge-triggered D flip-flop or as a level-sensitive latch. All four elements are driven from a single clock pin, but each element chooses its own clock polarity.

A shared active-high enable gates the elements. A shared asynchronous clear resets them. Each element has configuration bits that say whether it listens to the enable pin and whether it listens to the clear pin. An element that ignores either pin behaves as if that pin were tied to its harmless level. A global reset forces every element to zero whatever the other inputs are doing.

Beside the stored outputs, the cluster passes two things straight through with no storage: the bypass inputs go to the feed-through outputs, and the lookup results go to the combinational outputs. All configuration is static and arrives on input ports.

Top module: `storcl_cluster`

## Requirements
- R1: An element in flip-flop mode (`cfg_latch`=0) with `cfg_clk_inv`=0 loads its selected data on the rising edge of `clk_pin` while its enable is effective. At other times, and when its enable is not effective, it holds its value.
- R2: An element in flip-flop mode with `cfg_clk_inv`=1 loads its selected data on the falling edge of `clk_pin` instead, under the same enable rule as R1.
- R3: The data of element i is `di_in[i]` when `cfg_src_di[i]`=1 and `f_in[i]` when `cfg_src_di[i]`=0.
- R4: An element in latch mode (`cfg_latch`=1) is transparent while `clk_pin` is at its active level and holds its value otherwise. The active level is high when `cfg_clk_inv`=0 and low when `cfg_clk_inv`=1.
- R5: The enable is effective when `ce_pin`=1 or when `cfg_ce_used[i]`=0. With `cfg_ce_used[i]`=0 the pin has no effect. With `cfg_ce_used[i]`=1 and `ce_pin`=0, flip-flops do not load and latches stay closed.
- R6: When `clr_pin`=1 and `cfg_clr_used[i]`=1, `q_out[i]` is 0 at once, without waiting for a clock edge, and it stays 0 while the clear is held. With `cfg_clr_used[i]`=0 the clear pin has no effect.
- R7: While `grst`=1, all of `q_out` is 0 whatever the clock, enable, clear, data and configuration are.
- R8: `do_out` always equals `di_in` and `x_out` always equals `f_in`, in every storage configuration.
- R9: The four elements are configured independently. Any mix of modes, polarities, data sources and pin usage may be active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pin | input | 1 | Shared storage clock |
| grst | input | 1 | Global reset, active high, asynchronous |
| ce_pin | input | 1 | Shared clock enable, active high |
| clr_pin | input | 1 | Shared asynchronous clear, active high |
| cfg_latch | input | 4 | Per element: 1 selects latch mode, 0 selects flip-flop mode |
| cfg_clk_inv | input | 4 | Per element: 1 selects the falling edge or the low transparent level |
| cfg_src_di | input | 4 | Per element: 1 takes data from di_in, 0 takes data from f_in |
| cfg_ce_used | input | 4 | Per element: 0 makes the enable pin act as tied high |
| cfg_clr_used | input | 4 | Per element: 0 makes the clear pin act as tied low |
| f_in | input | 4 | Lookup result bits |
| di_in | input | 4 | Direct bypass input bits |
| q_out | output | 4 | Stored element outputs |
| do_out | output | 4 | Feed-through copy of di_in |
| x_out | output | 4 | Combinational copy of f_in |

## Verification
On every clock edge of the matching polarity, the assertions check four things: loading on the active edge, holding while the enable is off, the open latch following its data, and a forced zero under clear or global reset. They judge each element only from the pins and its own configuration. Two things can only be shown by the bench's scenarios. One is the instant of an asynchronous clear, which is checked between edges. The other is the step-by-step agreement with a reference model as all 32 per-element configurations rotate through the four elements at once, and the feed-through paths are part of that run.

// File: rtl/storcl_pkg.sv
`timescale 1ns/1ps
package storcl_pkg;

  // Static per-element control bits, as seen by the control decode.
  typedef struct packed {
    logic latch_mode;
    logic clk_inv;
    logic ce_used;
    logic clr_used;
  } elem_ctl_t;

  // An enable that is not used behaves as tied high.
  function automatic logic eff_enable(input logic ce_pin, input logic ce_used);
    return ce_pin | ~ce_used;
  endfunction

  // A clear that is not used behaves as tied low; global reset always wins.
  function automatic logic eff_reset(input logic clr_pin, input logic clr_used,
                                     input logic grst);
    return grst | (clr_pin & clr_used);
  endfunction

  // Polarity applied to the shared clock pin: high means edge/level active.
  function automatic logic eff_gate(input logic clk_pin, input logic inv);
    return clk_pin ^ inv;
  endfunction

  // Data source choice for one element.
  function automatic logic pick_data(input logic src_di, input logic f_bit,
                                     input logic di_bit);
    return src_di ? di_bit : f_bit;
  endfunction

endpackage

// File: rtl/storcl_ctrl.sv
`timescale 1ns/1ps
module storcl_ctrl
  import storcl_pkg::*;
#(
  parameter int NUM_ELEM = 4
) (
  input  logic                clk_pin,
  input  logic                grst,
  input  logic                ce_pin,
  input  logic                clr_pin,
  input  logic [NUM_ELEM-1:0] cfg_latch,
  input  logic [NUM_ELEM-1:0] cfg_clk_inv,
  input  logic [NUM_ELEM-1:0] cfg_ce_used,
  input  logic [NUM_ELEM-1:0] cfg_clr_used,
  output logic [NUM_ELEM-1:0] ck_eff,
  output logic [NUM_ELEM-1:0] en_eff,
  output logic [NUM_ELEM-1:0] rst_eff,
  output logic [NUM_ELEM-1:0] mode_latch
);

  elem_ctl_t ctl [NUM_ELEM];

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_dec
    always_comb begin
      ctl[i].latch_mode = cfg_latch[i];
      ctl[i].clk_inv    = cfg_clk_inv[i];
      ctl[i].ce_used    = cfg_ce_used[i];
      ctl[i].clr_used   = cfg_clr_used[i];
    end
    assign ck_eff[i]     = eff_gate(clk_pin, ctl[i].clk_inv);
    assign en_eff[i]     = eff_enable(ce_pin, ctl[i].ce_used);
    assign rst_eff[i]    = eff_reset(clr_pin, ctl[i].clr_used, grst);
    assign mode_latch[i] = ctl[i].latch_mode;
  end

endmodule

// File: rtl/storcl_dsel.sv
`timescale 1ns/1ps
module storcl_dsel
  import storcl_pkg::*;
#(
  parameter int NUM_ELEM = 4
) (
  input  logic [NUM_ELEM-1:0] f_in,
  input  logic [NUM_ELEM-1:0] di_in,
  input  logic [NUM_ELEM-1:0] cfg_src_di,
  output logic [NUM_ELEM-1:0] d_sel,
  output logic [NUM_ELEM-1:0] do_out,
  output logic [NUM_ELEM-1:0] x_out
);

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_sel
    assign d_sel[i] = pick_data(cfg_src_di[i], f_in[i], di_in[i]);
  end

  // Feed-through and combinational paths never pass through storage.
  assign do_out = di_in;
  assign x_out  = f_in;

endmodule

// File: rtl/storcl_elem.sv
`timescale 1ns/1ps
module storcl_elem (
  input  logic ck,
  input  logic en,
  input  logic rst,
  input  logic latch_mode,
  input  logic d,
  output logic q
);

  logic flop_q;
  logic latch_q;

  // Edge-triggered copy: ck already carries the selected polarity.
  always_ff @(posedge ck or posedge rst) begin
    if (rst)
      flop_q <= 1'b0;
    else if (en)
      flop_q <= d;
  end

  // Level-sensitive copy: open while ck is high and enabled.
  always_latch begin
    if (rst)
      latch_q = 1'b0;
    else if (ck && en)
      latch_q = d;
  end

  assign q = latch_mode ? latch_q : flop_q;

endmodule

// File: rtl/storcl_cluster.sv
`timescale 1ns/1ps
module storcl_cluster #(
  parameter int NUM_ELEM = 4
) (
  input  logic                clk_pin,
  input  logic                grst,
  input  logic                ce_pin,
  input  logic                clr_pin,
  input  logic [NUM_ELEM-1:0] cfg_latch,
  input  logic [NUM_ELEM-1:0] cfg_clk_inv,
  input  logic [NUM_ELEM-1:0] cfg_src_di,
  input  logic [NUM_ELEM-1:0] cfg_ce_used,
  input  logic [NUM_ELEM-1:0] cfg_clr_used,
  input  logic [NUM_ELEM-1:0] f_in,
  input  logic [NUM_ELEM-1:0] di_in,
  output logic [NUM_ELEM-1:0] q_out,
  output logic [NUM_ELEM-1:0] do_out,
  output logic [NUM_ELEM-1:0] x_out
);

  // Named internal events, visible to checkers.
  logic [NUM_ELEM-1:0] ck_eff;
  logic [NUM_ELEM-1:0] en_eff;
  logic [NUM_ELEM-1:0] rst_eff;
  logic [NUM_ELEM-1:0] mode_latch;
  logic [NUM_ELEM-1:0] d_sel;

  storcl_ctrl #(.NUM_ELEM(NUM_ELEM)) u_ctrl (
    .clk_pin      (clk_pin),
    .grst         (grst),
    .ce_pin       (ce_pin),
    .clr_pin      (clr_pin),
    .cfg_latch    (cfg_latch),
    .cfg_clk_inv  (cfg_clk_inv),
    .cfg_ce_used  (cfg_ce_used),
    .cfg_clr_used (cfg_clr_used),
    .ck_eff       (ck_eff),
    .en_eff       (en_eff),
    .rst_eff      (rst_eff),
    .mode_latch   (mode_latch)
  );

  storcl_dsel #(.NUM_ELEM(NUM_ELEM)) u_dsel (
    .f_in       (f_in),
    .di_in      (di_in),
    .cfg_src_di (cfg_src_di),
    .d_sel      (d_sel),
    .do_out     (do_out),
    .x_out      (x_out)
  );

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_elem
    storcl_elem u_elem (
      .ck         (ck_eff[i]),
      .en         (en_eff[i]),
      .rst        (rst_eff[i]),
      .latch_mode (mode_latch[i]),
      .d          (d_sel[i]),
      .q          (q_out[i])
    );
  end

endmodule

// File: rtl/storcl_checker.sv
`timescale 1ns/1ps
module storcl_checker #(
  parameter int NUM_ELEM = 4
) (
  input logic                clk_pin,
  input logic                grst,
  input logic                ce_pin,
  input logic                clr_pin,
  input logic [NUM_ELEM-1:0] cfg_latch,
  input logic [NUM_ELEM-1:0] cfg_clk_inv,
  input logic [NUM_ELEM-1:0] cfg_src_di,
  input logic [NUM_ELEM-1:0] cfg_ce_used,
  input logic [NUM_ELEM-1:0] cfg_clr_used,
  input logic [NUM_ELEM-1:0] f_in,
  input logic [NUM_ELEM-1:0] di_in,
  input logic [NUM_ELEM-1:0] q_out
);

  // R7: global reset holds every output at zero.
  p_grst_zero_r7: assert property (@(posedge clk_pin) grst |-> q_out == '0);

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_chk
    logic       en_i;
    logic       clr_i;
    logic       d_i;
    logic [4:0] cfg_i;
    assign en_i  = ce_pin | ~cfg_ce_used[i];
    assign clr_i = clr_pin & cfg_clr_used[i];
    assign d_i   = cfg_src_di[i] ? di_in[i] : f_in[i];
    assign cfg_i = {cfg_latch[i], cfg_clk_inv[i], cfg_src_di[i],
                    cfg_ce_used[i], cfg_clr_used[i]};

    p_rise_load_r1: assert property (@(posedge clk_pin) disable iff (grst)
      (!cfg_latch[i] && !cfg_clk_inv[i] && en_i && !clr_i)
      |=> (clr_i || !$stable(cfg_i) || q_out[i] == $past(d_i)));

    p_fall_load_r2: assert property (@(negedge clk_pin) disable iff (grst)
      (!cfg_latch[i] && cfg_clk_inv[i] && en_i && !clr_i)
      |=> (clr_i || !$stable(cfg_i) || q_out[i] == $past(d_i)));

    p_rise_hold_r5: assert property (@(posedge clk_pin) disable iff (grst)
      (!cfg_latch[i] && !cfg_clk_inv[i] && !en_i && !clr_i)
      |=> (clr_i || !$stable(cfg_i) || $stable(q_out[i])));

    p_fall_hold_r5: assert property (@(negedge clk_pin) disable iff (grst)
      (!cfg_latch[i] && cfg_clk_inv[i] && !en_i && !clr_i)
      |=> (clr_i || !$stable(cfg_i) || $stable(q_out[i])));

    // Sampled at negedge, the pin is still high: high-level latches are open.
    p_latch_high_open_r4: assert property (@(negedge clk_pin) disable iff (grst)
      (cfg_latch[i] && !cfg_clk_inv[i] && en_i && !clr_i) |-> q_out[i] == d_i);

    // Sampled at posedge, the pin is still low: low-level latches are open.
    p_latch_low_open_r4: assert property (@(posedge clk_pin) disable iff (grst)
      (cfg_latch[i] && cfg_clk_inv[i] && en_i && !clr_i) |-> q_out[i] == d_i);

    p_clear_zero_r6: assert property (@(posedge clk_pin) disable iff (grst)
      clr_i |-> q_out[i] == 1'b0);
  end

endmodule

bind storcl_cluster storcl_checker #(.NUM_ELEM(NUM_ELEM)) u_chk (
  .clk_pin      (clk_pin),
  .grst         (grst),
  .ce_pin       (ce_pin),
  .clr_pin      (clr_pin),
  .cfg_latch    (cfg_latch),
  .cfg_clk_inv  (cfg_clk_inv),
  .cfg_src_di   (cfg_src_di),
  .cfg_ce_used  (cfg_ce_used),
  .cfg_clr_used (cfg_clr_used),
  .f_in         (f_in),
  .di_in        (di_in),
  .q_out        (q_out)
);

// File: tb/storcl_cluster_bench.sv
`timescale 1ns/1ps
module storcl_cluster_bench;
  localparam int N = 4;
  localparam int RUN_CYCLES = 16;

  logic         clk_pin = 1'b0;
  logic         grst = 1'b0, ce_pin = 1'b0, clr_pin = 1'b0;
  logic [N-1:0] cfg_latch = '0, cfg_clk_inv = '0, cfg_src_di = '0;
  logic [N-1:0] cfg_ce_used = '0, cfg_clr_used = '0;
  logic [N-1:0] f_in = '0, di_in = '0;
  wire  [N-1:0] q_out, do_out, x_out;
  logic [N-1:0] exp_q = '0;
  logic [4:0]   next_cfg [N];
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk_pin = ~clk_pin;

  storcl_cluster #(.NUM_ELEM(N)) u_storcl_cluster (
    .clk_pin(clk_pin), .grst(grst), .ce_pin(ce_pin), .clr_pin(clr_pin),
    .cfg_latch(cfg_latch), .cfg_clk_inv(cfg_clk_inv), .cfg_src_di(cfg_src_di),
    .cfg_ce_used(cfg_ce_used), .cfg_clr_used(cfg_clr_used),
    .f_in(f_in), .di_in(di_in), .q_out(q_out), .do_out(do_out), .x_out(x_out)
  );

  function automatic logic en_of(int i);
    return ce_pin || !cfg_ce_used[i];
  endfunction
  function automatic logic zero_of(int i);
    return grst || (clr_pin && cfg_clr_used[i]);
  endfunction
  function automatic logic data_of(int i);   // R3: source select
    return cfg_src_di[i] ? di_in[i] : f_in[i];
  endfunction

  // Reference update at a clock edge (rising=1 means pin went high).
  task automatic at_edge(bit rising);
    for (int i = 0; i < N; i++) begin
      if (zero_of(i)) exp_q[i] = 1'b0;
      else if ((rising ^ cfg_clk_inv[i]) && en_of(i)) exp_q[i] = data_of(i);
    end
  endtask

  // Reference update after inputs change while the pin sits at level hi.
  task automatic at_level(bit hi);
    for (int i = 0; i < N; i++) begin
      if (zero_of(i)) exp_q[i] = 1'b0;
      else if (cfg_latch[i] && (hi ^ cfg_clk_inv[i]) && en_of(i)) exp_q[i] = data_of(i);
    end
  endtask

  function automatic string tag_of(int i);
    if (grst) return "R7";
    if (clr_pin && cfg_clr_used[i]) return "R6";
    if (!en_of(i)) return "R5";
    if (cfg_latch[i]) return "R4";
    if (cfg_clk_inv[i]) return "R2";
    return "R1";
  endfunction

  task automatic check_all();
    for (int i = 0; i < N; i++) begin
      checks++;
      if (q_out[i] !== exp_q[i]) begin
        failures++;
        $display("FAIL %s (R9 mix) elem %0d t=%0t q=%b expected=%b", tag_of(i), i,
                 $time, q_out[i], exp_q[i]);
      end
    end
    checks++;
    if (do_out !== di_in || x_out !== f_in) begin
      failures++;
      $display("FAIL R8 do=%h x=%h expected do=%h x=%h", do_out, x_out, di_in, f_in);
    end
  endtask

  // One clock cycle; clear changes only in the high phase so it spans an edge.
  task automatic run_cycle(bit reset_phase);
    @(posedge clk_pin);
    at_edge(1'b1);
    #1.25;
    grst = reset_phase;
    if (reset_phase) begin
      for (int i = 0; i < N; i++)
        {cfg_latch[i], cfg_clk_inv[i], cfg_src_di[i], cfg_ce_used[i], cfg_clr_used[i]} = next_cfg[i];
    end
    f_in = N'($urandom());
    di_in = N'($urandom());
    ce_pin = ($urandom() % 3) != 0;
    clr_pin = ($urandom() % 7) == 0;
    at_level(1'b1);
    #0.75 check_all();
    @(negedge clk_pin);
    at_edge(1'b0);
    #1.25;
    f_in = N'($urandom());
    di_in = N'($urandom());
    ce_pin = ($urandom() % 3) != 0;
    at_level(1'b0);
    #0.75 check_all();
  endtask

  initial begin
    #0.5 grst = 1'b1;
    #1.5 check_all();   // R7: reset state before the first edge
    // Each element steps through all 32 configurations, offset from the others (R9).
    for (int k = 0; k < 32; k++) begin
      for (int i = 0; i < N; i++) next_cfg[i] = 5'((k + 9 * i) % 32);
      run_cycle(1'b1);
      for (int c = 0; c < RUN_CYCLES; c++) run_cycle(1'b0);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at t=%0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule